// File: doc/BRIEF.md
# Scan Test Port with Configuration Trigger

This block is the four-wire boundary-scan test port of a configuration memory device. It runs the standard sixteen-state port controller and holds an 8-bit instruction register. It also holds four data registers: a one-bit bypass stage, a 32-bit identification word, a 32-bit user word, and a boundary register that covers the device's input and output pins. Two status inputs report whether in-system programming is active and whether read protection is set. Both are visible in the instruction capture word.

The test clock is oversampled in the system clock domain. TDO is updated on the falling test-clock edge, and its enable is raised only while a register is being shifted. One device-specific instruction is CONFIG. Once it is active, entering Run-Test/Idle from an Update state drives an active-low trigger pin low for a fixed number of system clocks. That pin restarts the configuration of an attached programmable device. The pad control instructions let the port drive pins from the boundary update cells, clamp them, or release all output enables.

Top module: `jtag_isp_tap`

## Requirements
- R1: Five test-clock cycles with TMS high bring the controller to Test-Logic-Reset from any state. In that state the active instruction becomes IDCODE, so a data scan after reset returns the identification word.
- R2: An instruction scan shifts 8 bits from TDI toward TDO, least significant bit first. Capture loads bits 7..5 = 0, bit 4 = ISP status, bit 3 = security status, bit 2 = 0 and bits 1..0 = 01.
- R3: The identification word is {version[3:0], 8'h50, part[7:0], 11'h049, 1'b1}. With the default parameters this is 32'h05006093.
- R4: The bypass register is one stage and captures 0. It is selected by BYPASS (FF), HIGHZ (FC), CLAMP (FA), CONFIG (EE) and any opcode not listed here.
- R5: USERCODE (FD) shifts out the 32-bit value on usercode_i, least significant bit first.
- R6: The boundary register has N_IN + 2*N_OUT cells, with index 0 nearest TDO. Cell i < N_IN is input pin i. For output pin j, cell N_IN+2j is its enable and cell N_IN+2j+1 is its data. SAMPLE/PRELOAD (01) captures these values and leaves the pads under functional control.
- R7: Update-DR under SAMPLE/PRELOAD or EXTEST (00) loads the output cells into the update stage. Under EXTEST the pads take their data and enables from that stage.
- R8: CLAMP drives the pads from the update stage while the bypass register is in the scan path.
- R9: HIGHZ forces every pad enable to 0. Under any other instruction except EXTEST and CLAMP, the pads follow core_out_i and core_oe_i.
- R10: cfg_trig_no is high after reset. A CONFIG trigger holds it low for CLK_MHZ*PULSE_NS/1000 system clocks, which is 50 clocks (400 ns) by default.
- R11: A trigger happens only when the controller moves from Update-IR or Update-DR into Run-Test/Idle while CONFIG is active. Staying in Run-Test/Idle gives no further pulse.
- R12: TDO changes only after a falling test-clock edge. tdo_en_o is high while Shift-IR or Shift-DR is in progress and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the test port |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tck_i | input | 1 | Test clock |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Test data in |
| tdo_o | output | 1 | Test data out |
| tdo_en_o | output | 1 | Enable for the TDO driver |
| isp_mode_i | input | 1 | In-system programming is active |
| secure_i | input | 1 | Read protection is set |
| usercode_i | input | 32 | User word shown by USERCODE |
| pin_in_i | input | N_IN | Input pin levels seen by the boundary cells |
| core_out_i | input | N_OUT | Functional output data |
| core_oe_i | input | N_OUT | Functional output enables |
| pad_out_o | output | N_OUT | Data driven to output pads |
| pad_oe_o | output | N_OUT | Enables driven to output pads |
| cfg_trig_no | output | 1 | Configuration trigger, active low |

## Verification
The hardest case to reach is the exact width and count of trigger pulses. A pulse requires CONFIG to be in the instruction register and the controller to pass through an Update state into Run-Test/Idle. Only that path may trigger; idling must not. The bench loads CONFIG with a full instruction scan and then measures how many system clocks the pin stays low. It then holds TMS low for many test clocks to confirm no repeat, and runs a bypass data scan to confirm that Update-DR starts a second pulse. The boundary update stage is also reached indirectly: a known pattern is preloaded under SAMPLE/PRELOAD, and the bench then observes it on the pads under EXTEST and CLAMP.

// File: rtl/jtag_isp_pkg.sv
package jtag_isp_pkg;

  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h01;
  localparam logic [IR_W-1:0] OP_CLAMP    = 8'hFA;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 8'hFC;
  localparam logic [IR_W-1:0] OP_USERCODE = 8'hFD;
  localparam logic [IR_W-1:0] OP_IDCODE   = 8'hFE;
  localparam logic [IR_W-1:0] OP_CONFIG   = 8'hEE;
  localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_USR, SEL_BSR} dr_sel_e;

  function automatic dr_sel_e dr_select(logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:            return SEL_ID;
      OP_USERCODE:          return SEL_USR;
      OP_EXTEST, OP_SAMPLE: return SEL_BSR;
      default:              return SEL_BYP;
    endcase
  endfunction

endpackage

// File: rtl/jtag_edge_sync.sv
module jtag_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tck_i,
  input  logic tms_i,
  input  logic tdi_i,
  output logic rise_o,
  output logic fall_o,
  output logic tms_o,
  output logic tdi_o
);
  logic [SYNC_STAGES-1:0] tck_p, tms_p, tdi_p;
  logic tck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tck_p <= '0;
      tms_p <= '1;
      tdi_p <= '1;
      tck_d <= 1'b0;
    end else begin
      tck_p <= {tck_p[SYNC_STAGES-2:0], tck_i};
      tms_p <= {tms_p[SYNC_STAGES-2:0], tms_i};
      tdi_p <= {tdi_p[SYNC_STAGES-2:0], tdi_i};
      tck_d <= tck_p[SYNC_STAGES-1];
    end
  end

  assign rise_o = tck_p[SYNC_STAGES-1] & ~tck_d;
  assign fall_o = ~tck_p[SYNC_STAGES-1] & tck_d;
  assign tms_o  = tms_p[SYNC_STAGES-1];
  assign tdi_o  = tdi_p[SYNC_STAGES-1];
endmodule

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_isp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ST_TLR;
    else if (rise_i) state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/jtag_ir.sv
module jtag_ir
  import jtag_isp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_i,
  input  logic            fall_i,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  input  logic            isp_mode_i,
  input  logic            secure_i,
  output logic [IR_W-1:0] ir_o,
  output logic            tdo_o
);
  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (rise_i) begin
      if (state_i == ST_CAP_IR)     sr_q <= {3'b000, isp_mode_i, secure_i, 3'b001};
      else if (state_i == ST_SH_IR) sr_q <= {tdi_i, sr_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ir_q <= OP_IDCODE;
    else if (state_i == ST_TLR)             ir_q <= OP_IDCODE;
    else if (fall_i && state_i == ST_UPD_IR) ir_q <= sr_q;
  end

  assign ir_o  = ir_q;
  assign tdo_o = sr_q[0];
endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
  import jtag_isp_pkg::*;
#(
  parameter int          N_IN    = 2,
  parameter int          N_OUT   = 2,
  parameter logic [3:0]  VERSION = 4'h0,
  parameter logic [7:0]  PART_ID = 8'h06
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  tap_state_e       state_i,
  input  logic             tdi_i,
  input  logic [IR_W-1:0]  ir_i,
  input  logic [31:0]      usercode_i,
  input  logic [N_IN-1:0]  pin_in_i,
  input  logic [N_OUT-1:0] core_out_i,
  input  logic [N_OUT-1:0] core_oe_i,
  output logic [N_OUT-1:0] pad_out_o,
  output logic [N_OUT-1:0] pad_oe_o,
  output logic             tdo_o
);
  localparam int BSR_LEN = N_IN + 2 * N_OUT;
  localparam int UPD_LEN = 2 * N_OUT;
  localparam logic [31:0] ID_VAL = {VERSION, 8'h50, PART_ID, 11'h049, 1'b1};

  dr_sel_e sel;
  logic cap, shift, upd;
  logic byp_q;
  logic [31:0] id_sr, usr_sr;
  logic [BSR_LEN-1:0] bsr_sr, bsr_cap;
  logic [UPD_LEN-1:0] bsr_upd;
  logic [N_OUT-1:0] upd_out, upd_oe;

  assign sel   = dr_select(ir_i);
  assign cap   = rise_i && (state_i == ST_CAP_DR);
  assign shift = rise_i && (state_i == ST_SH_DR);
  assign upd   = fall_i && (state_i == ST_UPD_DR);

  genvar gi;
  generate
    for (gi = 0; gi < N_IN; gi++) begin : g_in_cell
      assign bsr_cap[gi] = pin_in_i[gi];
    end
    for (gi = 0; gi < N_OUT; gi++) begin : g_out_cell
      assign bsr_cap[N_IN+2*gi]   = pad_oe_o[gi];
      assign bsr_cap[N_IN+2*gi+1] = pad_out_o[gi];
      assign upd_oe[gi]           = bsr_upd[2*gi];
      assign upd_out[gi]          = bsr_upd[2*gi+1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q  <= 1'b0;
      id_sr  <= '0;
      usr_sr <= '0;
      bsr_sr <= '0;
    end else if (cap) begin
      unique case (sel)
        SEL_ID:  id_sr  <= ID_VAL;
        SEL_USR: usr_sr <= usercode_i;
        SEL_BSR: bsr_sr <= bsr_cap;
        default: byp_q  <= 1'b0;
      endcase
    end else if (shift) begin
      unique case (sel)
        SEL_ID:  id_sr  <= {tdi_i, id_sr[31:1]};
        SEL_USR: usr_sr <= {tdi_i, usr_sr[31:1]};
        SEL_BSR: bsr_sr <= {tdi_i, bsr_sr[BSR_LEN-1:1]};
        default: byp_q  <= tdi_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  bsr_upd <= '0;
    else if (upd && sel == SEL_BSR) bsr_upd <= bsr_sr[BSR_LEN-1:N_IN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_out_o <= '0;
      pad_oe_o  <= '0;
    end else if (ir_i == OP_HIGHZ) begin
      pad_out_o <= core_out_i;
      pad_oe_o  <= '0;
    end else if (ir_i == OP_EXTEST || ir_i == OP_CLAMP) begin
      pad_out_o <= upd_out;
      pad_oe_o  <= upd_oe;
    end else begin
      pad_out_o <= core_out_i;
      pad_oe_o  <= core_oe_i;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ID:  tdo_o = id_sr[0];
      SEL_USR: tdo_o = usr_sr[0];
      SEL_BSR: tdo_o = bsr_sr[0];
      default: tdo_o = byp_q;
    endcase
  end
endmodule

// File: rtl/jtag_cfg_pulse.sv
module jtag_cfg_pulse #(
  parameter int PULSE_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic trig_no
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
    else if (start_i)             cnt_q <= LOAD;
  end

  assign trig_no = (cnt_q == '0);
endmodule

// File: rtl/jtag_isp_tap.sv
module jtag_isp_tap
  import jtag_isp_pkg::*;
#(
  parameter int         N_IN        = 2,
  parameter int         N_OUT       = 2,
  parameter logic [3:0] VERSION     = 4'h0,
  parameter logic [7:0] PART_ID     = 8'h06,
  parameter int         CLK_MHZ     = 125,
  parameter int         PULSE_NS    = 400,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tck_i,
  input  logic             tms_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  output logic             tdo_en_o,
  input  logic             isp_mode_i,
  input  logic             secure_i,
  input  logic [31:0]      usercode_i,
  input  logic [N_IN-1:0]  pin_in_i,
  input  logic [N_OUT-1:0] core_out_i,
  input  logic [N_OUT-1:0] core_oe_i,
  output logic [N_OUT-1:0] pad_out_o,
  output logic [N_OUT-1:0] pad_oe_o,
  output logic             cfg_trig_no
);
  localparam int PULSE_CYC = CLK_MHZ * PULSE_NS / 1000;

  logic tck_rise, tck_fall, tms_s, tdi_s;
  tap_state_e tap_state;
  logic [IR_W-1:0] ir_active;
  logic ir_tdo, dr_tdo, serial_out, cfg_start;

  jtag_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .tck_i, .tms_i, .tdi_i,
    .rise_o(tck_rise), .fall_o(tck_fall), .tms_o(tms_s), .tdi_o(tdi_s)
  );

  jtag_tap_fsm u_fsm (
    .clk_i, .rst_ni, .rise_i(tck_rise), .tms_i(tms_s), .state_o(tap_state)
  );

  jtag_ir u_ir (
    .clk_i, .rst_ni, .rise_i(tck_rise), .fall_i(tck_fall), .state_i(tap_state),
    .tdi_i(tdi_s), .isp_mode_i, .secure_i, .ir_o(ir_active), .tdo_o(ir_tdo)
  );

  jtag_dr_bank #(.N_IN(N_IN), .N_OUT(N_OUT), .VERSION(VERSION), .PART_ID(PART_ID)) u_dr (
    .clk_i, .rst_ni, .rise_i(tck_rise), .fall_i(tck_fall), .state_i(tap_state),
    .tdi_i(tdi_s), .ir_i(ir_active), .usercode_i, .pin_in_i, .core_out_i,
    .core_oe_i, .pad_out_o, .pad_oe_o, .tdo_o(dr_tdo)
  );

  // trigger only on the Update -> Run-Test/Idle transition
  assign cfg_start = tck_rise && !tms_s && ir_active == OP_CONFIG &&
                     (tap_state == ST_UPD_IR || tap_state == ST_UPD_DR);

  jtag_cfg_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i, .rst_ni, .start_i(cfg_start), .trig_no(cfg_trig_no)
  );

  assign serial_out = (tap_state == ST_SH_IR) ? ir_tdo : dr_tdo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_en_o <= 1'b0;
    end else if (tck_fall) begin
      tdo_o    <= serial_out;
      tdo_en_o <= (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);
    end
  end
endmodule

// File: rtl/jtag_isp_tap_chk.sv
module jtag_isp_tap_chk
  import jtag_isp_pkg::*;
#(
  parameter int PULSE_CYC = 50,
  parameter int N_OUT     = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input tap_state_e       tap_state,
  input logic             tck_fall,
  input logic [IR_W-1:0]  ir_active,
  input logic             tdo_o,
  input logic             tdo_en_o,
  input logic [N_OUT-1:0] pad_oe_o,
  input logic             cfg_trig_no
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_cnt <= '0;
    else if (!cfg_trig_no) low_cnt <= low_cnt + 1'b1;
    else                  low_cnt <= '0;
  end

  AST_TLR_IDCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_state == ST_TLR && $past(tap_state) == ST_TLR) |-> ir_active == OP_IDCODE); // R1

  AST_HIGHZ_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_active == OP_HIGHZ) |=> pad_oe_o == '0); // R9

  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_trig_no) |-> low_cnt == 16'(PULSE_CYC)); // R10

  AST_PULSE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_trig_no) |-> (tap_state == ST_RTI && ir_active == OP_CONFIG)); // R11

  AST_TDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tck_fall |=> $stable(tdo_o)); // R12

  AST_TDO_EN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdo_en_o |-> (tap_state == ST_SH_IR || tap_state == ST_SH_DR ||
                  tap_state == ST_EX1_IR || tap_state == ST_EX1_DR)); // R12
endmodule

bind jtag_isp_tap jtag_isp_tap_chk #(.PULSE_CYC(PULSE_CYC), .N_OUT(N_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tap_state(tap_state), .tck_fall(tck_fall),
  .ir_active(ir_active), .tdo_o(tdo_o), .tdo_en_o(tdo_en_o),
  .pad_oe_o(pad_oe_o), .cfg_trig_no(cfg_trig_no)
);

// File: tb/jtag_isp_tap_tb.sv
module jtag_isp_tap_tb;
  localparam int N_IN = 2, N_OUT = 2, HALF = 6, PULSE = 50;
  localparam logic [63:0] ID_EXP = 64'({4'h0, 8'h50, 8'h06, 11'h049, 1'b1});

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b1;
  logic tdo, tdo_en, isp = 1'b1, sec = 1'b0, cfg_n;
  logic [31:0] ucode = 32'hCAFE1234;
  logic [N_IN-1:0] pin_in = 2'b01;
  logic [N_OUT-1:0] core_out = 2'b10, core_oe = 2'b11, pad_out, pad_oe;

  int n_chk = 0, n_fail = 0, stable_err = 0, en_err = 0;
  int low_cyc = 0, pulses = 0;
  logic prev_cfg = 1'b1;
  string exp_req_q[$];
  logic [63:0] exp_val_q[$], act_q[$];

  always #4 clk = ~clk;

  jtag_isp_tap u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tck_i(tck), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_en_o(tdo_en), .isp_mode_i(isp), .secure_i(sec),
    .usercode_i(ucode), .pin_in_i(pin_in), .core_out_i(core_out),
    .core_oe_i(core_oe), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .cfg_trig_no(cfg_n)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (act_q.size() > 0 && exp_val_q.size() > 0)
      check(exp_req_q.pop_front(), act_q.pop_front(), exp_val_q.pop_front());
  end

  always @(negedge clk) begin
    if (!cfg_n) low_cyc++;
    if (prev_cfg && !cfg_n) pulses++;
    prev_cfg = cfg_n;
  end

  task automatic push_exp(string req, logic [63:0] v);
    exp_req_q.push_back(req);
    exp_val_q.push_back(v);
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(input logic tms_v, input logic tdi_v, input logic in_shift,
                      output logic tdo_v);
    logic pre;
    tms = tms_v;
    tdi = tdi_v;
    wait_clk(HALF);
    pre = tdo;
    if (in_shift && tdo_en !== 1'b1) en_err++;
    tck = 1'b1;
    wait_clk(HALF);
    if (tdo !== pre) stable_err++;
    tck = 1'b0;
    tdo_v = pre;
  endtask

  task automatic tap_reset();
    logic d;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, d);
    step(1'b0, 1'b1, 1'b0, d);
  endtask

  task automatic scan_ir(input logic [7:0] op, output logic [63:0] cap);
    logic d;
    cap = '0;
    step(1'b1, 1'b0, 1'b0, d);
    step(1'b1, 1'b0, 1'b0, d);
    step(1'b0, 1'b0, 1'b0, d);
    step(1'b0, 1'b0, 1'b0, d);
    for (int i = 0; i < 8; i++) begin
      step(i == 7, op[i], 1'b1, d);
      cap[i] = d;
    end
    step(1'b1, 1'b0, 1'b0, d);
    step(1'b0, 1'b0, 1'b0, d);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic d;
    dout = '0;
    step(1'b1, 1'b0, 1'b0, d);
    step(1'b0, 1'b0, 1'b0, d);
    step(1'b0, 1'b0, 1'b0, d);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], 1'b1, d);
      dout[i] = d;
    end
    step(1'b1, 1'b0, 1'b0, d);
    step(1'b0, 1'b0, 1'b0, d);
  endtask

  task automatic ir_sc(string req, logic [7:0] op, logic [63:0] exp_cap);
    logic [63:0] c;
    push_exp(req, exp_cap);
    scan_ir(op, c);
    act_q.push_back(c);
  endtask

  task automatic dr_sc(string req, int n, logic [63:0] din, logic [63:0] exp);
    logic [63:0] o;
    push_exp(req, exp);
    scan_dr(n, din, o);
    act_q.push_back(o);
  endtask

  initial begin
    logic d;
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(4);
    check("R10 reset trigger high", 64'(cfg_n), 64'd1);
    check("R12 reset tdo_en low", 64'(tdo_en), 64'd0);
    check("R9 reset pads functional", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));

    tap_reset();
    dr_sc("R1 R3 idcode after reset", 32, 64'h0, ID_EXP);
    check("R12 tdo_en low after scan", 64'(tdo_en), 64'd0);

    // R2 capture with isp=1 sec=0, R4 bypass
    ir_sc("R2 capture isp", 8'hFF, 64'h11);
    dr_sc("R4 bypass delay", 8, 64'hA5, 64'h4A);

    isp = 1'b0; sec = 1'b1;
    ir_sc("R2 capture secure", 8'hFD, 64'h09);
    dr_sc("R5 usercode", 32, 64'h0, 64'hCAFE1234);

    ir_sc("R2 capture unlisted", 8'h5A, 64'h09);
    dr_sc("R4 unlisted opcode bypass", 8, 64'h3C, 64'h78);

    // R1 reset out of Shift-DR
    ir_sc("R2 capture usercode again", 8'hFD, 64'h09);
    step(1'b1, 1'b0, 1'b0, d);
    step(1'b0, 1'b0, 1'b0, d);
    step(1'b0, 1'b0, 1'b0, d);
    step(1'b0, 1'b1, 1'b1, d);
    tap_reset();
    dr_sc("R1 idcode after mid-shift reset", 32, 64'h0, ID_EXP);

    // R6 sample + preload out0=1 oe0=1 out1=0 oe1=0
    ir_sc("R2 capture sample", 8'h01, 64'h09);
    dr_sc("R6 boundary capture order", 6, 64'h0C, 64'h35);
    wait_clk(4);
    check("R6 pads functional under sample", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));

    ir_sc("R2 capture extest", 8'h00, 64'h09);
    wait_clk(4);
    check("R7 extest pad data", 64'(pad_out), 64'h1);
    check("R7 extest pad enable", 64'(pad_oe), 64'h1);

    ir_sc("R2 capture highz", 8'hFC, 64'h09);
    wait_clk(4);
    check("R9 highz enables off", 64'(pad_oe), 64'h0);
    dr_sc("R4 highz bypass", 8, 64'hF0, 64'hE0);

    ir_sc("R2 capture clamp", 8'hFA, 64'h09);
    wait_clk(4);
    check("R8 clamp pads", 64'({pad_out, pad_oe}), 64'h5);
    dr_sc("R8 R4 clamp bypass", 8, 64'h81, 64'h02);

    ir_sc("R2 capture idcode", 8'hFE, 64'h09);
    wait_clk(4);
    check("R9 pads functional again", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
    check("R10 no pulse before config", 64'(pulses), 64'd0);

    low_cyc = 0;
    ir_sc("R2 capture config", 8'hEE, 64'h09);
    wait_clk(80);
    check("R10 one pulse", 64'(pulses), 64'd1);
    check("R10 pulse width", 64'(low_cyc), 64'(PULSE));
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0, d);
    wait_clk(80);
    check("R11 idle no repeat", 64'(pulses), 64'd1);
    dr_sc("R4 config bypass", 8, 64'h01, 64'h02);
    wait_clk(80);
    check("R11 update-dr retrigger", 64'(pulses), 64'd2);
    check("R10 total low cycles", 64'(low_cyc), 64'(2 * PULSE));

    check("R12 tdo stable while tck high", 64'(stable_err), 64'd0);
    check("R12 tdo_en during shift", 64'(en_err), 64'd0);
    wait_clk(4);
    check("R2 scoreboard drained", 64'(act_q.size()), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule